// File: doc/BRIEF.md
# SHA-1 Block Compression Engine

This engine runs the SHA-1 compression function on one 512-bit message block per request. It performs one round per clock cycle and folds the result into a 160-bit chaining value. A requester offers a block with `blk_valid`. The engine takes it only while it is idle. A flag sent with the block says whether the block opens a new message, in which case the standard initial value is used as the chaining input, or whether it continues the message, in which case the previous digest is used.

The message schedule is built on the fly in a ring of sixteen 32-bit slots indexed by round number modulo 16. The five working words keep their registers; only a rotating role pointer moves each round. Message padding and byte buffering belong to the requester.

The controller has three states. ST_IDLE waits for a block. ST_ROUND runs rounds 0 to 79. ST_FINAL adds the working words into the chaining value. The transitions are:
- ST_IDLE to ST_ROUND when a block is accepted.
- ST_ROUND to itself while the round index is below 79.
- ST_ROUND to ST_FINAL after round 79.
- ST_FINAL to ST_IDLE unconditionally, raising `done` on entry to ST_IDLE.

Top module: `sha1_core`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `digest` equals the initial value 67452301 EFCDAB89 98BADCFE 10325476 C3D2E1F0. The first 32-bit word sits in `digest[159:128]`.
- R2: A block accepted with `blk_first`=1 is compressed from the initial value. The padded empty message gives da39a3ee5e6b4b0d3255bfef95601890afd80709, and the padded "abc" gives a9993e364706816aba3e25717850c26c9cd0d89d.
- R3: A block accepted with `blk_first`=0 is compressed from the current `digest`. The two-block padded 56-byte message "abcdbcdecdef...nopq" gives 84983e441c3bd26ebaae4aa1f95129e5e54670f1.
- R4: A block is accepted on a rising edge where `blk_valid`=1 and `busy`=0. `done` rises on the 81st rising edge after that acceptance edge, and `busy` is 1 from the acceptance edge until that edge.
- R5: `done` is high for exactly one cycle per accepted block.
- R6: `blk_valid` is ignored while `busy`=1. A block offered during a computation changes neither the resulting digest nor the idle state that follows.
- R7: Byte 0 of the block is `blk_data[511:504]`, and schedule words 0 to 15 are the block read as big-endian 32-bit words, word 0 in `blk_data[511:480]`.
- R8: For arbitrary blocks and chaining sequences, `digest` equals the 80-round SHA-1 compression: the four round functions and constants by 20-round phase, and the expanded schedule w[i]=rol1(w[i-16]^w[i-14]^w[i-8]^w[i-3]).
- R9: `digest` changes only on the edge that raises `done`, and holds its value while idle and while a block is being computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | Block offered; accepted when idle |
| blk_first | input | 1 | Block opens a new message (use initial value) |
| blk_data | input | 512 | Message block, byte 0 in the top bits |
| busy | output | 1 | Engine computing a block |
| done | output | 1 | One-cycle pulse: digest updated |
| digest | output | 160 | Chaining value, first word in the top bits |

## Verification
The assertions assume that `blk_valid` drops within a few cycles once a block is taken. They also assume that `blk_data` and `blk_first` matter only on the acceptance edge, so the schedule load is the sole point where the inputs are sampled.

The bench offers each block for one cycle at idle. On some blocks it deliberately raises `blk_valid` again mid-computation with altered data, then lowers it well before round 79, so that the ignore rule is exercised without a second acceptance at the end. Random blocks mix new-message and continuation flags, with the first one always opening a message.

// File: rtl/sha1_pkg.sv
package sha1_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 16;
    localparam int ROUNDS    = 80;
    localparam int PHASE_LEN = 20;
    localparam int NUM_VARS  = 5;
    localparam int BLOCK_W   = NUM_WORDS * WORD_W;
    localparam int STATE_W   = NUM_VARS * WORD_W;
    localparam int RND_W     = $clog2(ROUNDS);
    localparam int SLOT_W    = $clog2(NUM_WORDS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RND_W-1:0]  rnd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROUND,
        ST_FINAL
    } state_e;

    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t iv_word(input int unsigned k);
        case (k)
            0:       return 32'h67452301;
            1:       return 32'hEFCDAB89;
            2:       return 32'h98BADCFE;
            3:       return 32'h10325476;
            default: return 32'hC3D2E1F0;
        endcase
    endfunction

    function automatic word_t round_k(input rnd_t r);
        if (r < rnd_t'(PHASE_LEN))         return 32'h5A827999;
        else if (r < rnd_t'(2*PHASE_LEN))  return 32'h6ED9EBA1;
        else if (r < rnd_t'(3*PHASE_LEN))  return 32'h8F1BBCDC;
        else                               return 32'hCA62C1D6;
    endfunction

    function automatic word_t round_f(input rnd_t r, input word_t b, input word_t c,
                                      input word_t d);
        if (r < rnd_t'(PHASE_LEN))         return (b & (c ^ d)) ^ d;
        else if (r < rnd_t'(2*PHASE_LEN))  return b ^ c ^ d;
        else if (r < rnd_t'(3*PHASE_LEN))  return (c & d) ^ (b & (c ^ d));
        else                               return b ^ c ^ d;
    endfunction
endpackage

// File: rtl/sha1_ctrl.sv
module sha1_ctrl
    import sha1_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic blk_valid,
    output logic busy,
    output logic load,
    output logic step,
    output logic fin,
    output rnd_t rnd,
    output logic done
);
    state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (blk_valid) state_nx = ST_ROUND;
            ST_ROUND: if (rnd == rnd_t'(ROUNDS-1)) state_nx = ST_FINAL;
            ST_FINAL: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rnd   <= '0;
        end else begin
            state <= state_nx;
            if (load)      rnd <= '0;
            else if (step) rnd <= rnd + rnd_t'(1);
        end
    end

    always_comb begin
        busy = (state != ST_IDLE);
        load = (state == ST_IDLE) && blk_valid;
        step = (state == ST_ROUND);
        fin  = (state == ST_FINAL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= fin;
    end

    AST_RND_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> rnd < rnd_t'(ROUNDS)); // R4
    AST_FIN_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rnd == rnd_t'(ROUNDS-1)) |=> fin); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_IDLE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R4
    AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && blk_valid) |=> !(step && rnd == '0)); // R6
endmodule

// File: rtl/sha1_sched.sv
module sha1_sched
    import sha1_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  rnd_t               rnd,
    input  logic [BLOCK_W-1:0] blk,
    output word_t              w_cur
);
    word_t              slot [NUM_WORDS];
    logic [SLOT_W-1:0]  idx, i_m14, i_m8, i_m3;
    word_t              expanded;
    logic               expand_phase;

    always_comb begin
        idx          = rnd[SLOT_W-1:0];
        i_m14        = idx + SLOT_W'(2);
        i_m8         = idx + SLOT_W'(8);
        i_m3         = idx + SLOT_W'(13);
        expand_phase = (rnd >= rnd_t'(NUM_WORDS));
        expanded     = rotl(slot[idx] ^ slot[i_m14] ^ slot[i_m8] ^ slot[i_m3], 1);
        w_cur        = expand_phase ? expanded : slot[idx];
    end

    for (genvar j = 0; j < NUM_WORDS; j++) begin : g_slot
        always_ff @(posedge clk) begin
            if (load)
                slot[j] <= blk[BLOCK_W-1-j*WORD_W -: WORD_W];
            else if (step && expand_phase && idx == SLOT_W'(j))
                slot[j] <= expanded;
        end
    end

    AST_LOAD_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> slot[0] == $past(blk[BLOCK_W-1 -: WORD_W])); // R7
    AST_LOAD_WORD15: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> slot[NUM_WORDS-1] == $past(blk[WORD_W-1:0])); // R7
endmodule

// File: rtl/sha1_datapath.sv
module sha1_datapath
    import sha1_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               first,
    input  logic               step,
    input  logic               fin,
    input  rnd_t               rnd,
    input  word_t              w_cur,
    output logic [STATE_W-1:0] digest
);
    word_t       v     [NUM_VARS];
    word_t       chain [NUM_VARS];
    logic [2:0]  ptr;
    logic        first_q;
    logic [2:0]  ia, ib, ic, id, ie;
    word_t       t_new;

    function automatic logic [2:0] slot_of(input logic [2:0] p, input int unsigned k);
        logic [3:0] s;
        s = {1'b0, p} + 4'(k);
        return (s >= 4'(NUM_VARS)) ? 3'(s - 4'(NUM_VARS)) : s[2:0];
    endfunction

    always_comb begin
        ia    = ptr;
        ib    = slot_of(ptr, 1);
        ic    = slot_of(ptr, 2);
        id    = slot_of(ptr, 3);
        ie    = slot_of(ptr, 4);
        t_new = rotl(v[ia], 5) + round_f(rnd, v[ib], v[ic], v[id]) + v[ie]
              + round_k(rnd) + w_cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            first_q <= 1'b0;
            for (int k = 0; k < NUM_VARS; k++) begin
                v[k]     <= '0;
                chain[k] <= iv_word(k);
            end
        end else if (load) begin
            ptr     <= '0;
            first_q <= first;
            for (int k = 0; k < NUM_VARS; k++)
                v[k] <= first ? iv_word(k) : chain[k];
        end else if (step) begin
            v[ie] <= t_new;
            v[ib] <= rotl(v[ib], 30);
            ptr   <= ie;
        end else if (fin) begin
            for (int k = 0; k < NUM_VARS; k++)
                chain[k] <= (first_q ? iv_word(k) : chain[k]) + v[k];
        end
    end

    for (genvar k = 0; k < NUM_VARS; k++) begin : g_out
        assign digest[STATE_W-1-k*WORD_W -: WORD_W] = chain[k];
    end

    AST_PTR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> ptr == '0); // R8
    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(digest)); // R9
endmodule

// File: rtl/sha1_core.sv
module sha1_core
    import sha1_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               blk_valid,
    input  logic               blk_first,
    input  logic [BLOCK_W-1:0] blk_data,
    output logic               busy,
    output logic               done,
    output logic [STATE_W-1:0] digest
);
    logic  load, step, fin;
    rnd_t  rnd;
    word_t w_cur;

    sha1_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid),
        .busy(busy), .load(load), .step(step), .fin(fin), .rnd(rnd), .done(done)
    );

    sha1_sched u_sched (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .rnd(rnd),
        .blk(blk_data), .w_cur(w_cur)
    );

    sha1_datapath u_dp (
        .clk(clk), .rst_n(rst_n), .load(load), .first(blk_first), .step(step),
        .fin(fin), .rnd(rnd), .w_cur(w_cur), .digest(digest)
    );

    AST_ACCEPT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && !busy) |=> busy); // R4
endmodule

// File: tb/sha1_core_tb.sv
module sha1_core_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         blk_valid = 1'b0;
    logic         blk_first = 1'b0;
    logic [511:0] blk_data = '0;
    logic         busy, done;
    logic [159:0] digest;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;
    logic [159:0] model_h;

    localparam logic [159:0] IV = 160'h67452301EFCDAB8998BADCFE10325476C3D2E1F0;

    always #4 clk = ~clk;

    sha1_core u_dut (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_first(blk_first),
        .blk_data(blk_data), .busy(busy), .done(done), .digest(digest)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [159:0] compress(input logic [159:0] h, input logic [511:0] b);
        logic [31:0] w [80];
        logic [31:0] a, bb, c, d, e, f, k, t;
        for (int i = 0; i < 16; i++) w[i] = b[511-32*i -: 32];
        for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
        a = h[159:128]; bb = h[127:96]; c = h[95:64]; d = h[63:32]; e = h[31:0];
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (bb & c) | (~bb & d);          k = 32'h5A827999; end
            else if (i < 40) begin f = bb ^ c ^ d;                    k = 32'h6ED9EBA1; end
            else if (i < 60) begin f = (bb & c) | (bb & d) | (c & d); k = 32'h8F1BBCDC; end
            else             begin f = bb ^ c ^ d;                    k = 32'hCA62C1D6; end
            t = rl(a, 5) + f + e + k + w[i];
            e = d; d = c; c = rl(bb, 30); bb = a; a = t;
        end
        return {h[159:128] + a, h[127:96] + bb, h[95:64] + c, h[63:32] + d, h[31:0] + e};
    endfunction

    task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Offers one block at idle; poke re-raises blk_valid mid-computation with altered data.
    task automatic run_block(input logic [511:0] b, input logic first, input bit poke);
        int  cnt;
        bit  busy_gap;
        while (busy) @(negedge clk);
        blk_valid = 1'b1; blk_first = first; blk_data = b;
        cnt = 0; busy_gap = 0;
        while (!done && cnt < 200) begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) blk_valid = 1'b0;
            if (poke && cnt == 10) begin
                blk_valid = 1'b1; blk_data = ~b; blk_first = ~first;
            end
            if (poke && cnt == 12) blk_valid = 1'b0;
            if (!done && !busy) busy_gap = 1;
        end
        if (first) model_h = IV;
        model_h = compress(model_h, b);
        // sample cnt=j follows edge j-1; done after edge 81 => cnt 82 (R4)
        chk("R4 done latency", 160'(cnt), 160'd82);
        chk("R4 busy held", 160'(busy_gap), 160'd0);
        chk("R8 digest", digest, model_h);
        @(negedge clk);
        chk("R5 done pulse width", 160'(done), 160'd0);
        if (poke) chk("R6 no late accept", 160'(busy), 160'd0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [511:0] b;
        logic [159:0] held;
        logic [447:0] msg56;
        void'($urandom(32'd1729));
        model_h = IV;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", 160'(busy), 160'd0);
        chk("R1 done after reset", 160'(done), 160'd0);
        chk("R1 digest after reset", digest, IV);

        // R2, R7: empty message, byte 0 in bits 511:504
        run_block({8'h80, 440'h0, 64'd0}, 1'b1, 1'b0);
        chk("R2 empty digest", digest, 160'hda39a3ee5e6b4b0d3255bfef95601890afd80709);

        // R2, R6: "abc" with a mid-run poke
        run_block({24'h616263, 8'h80, 416'h0, 64'd24}, 1'b1, 1'b1);
        chk("R2 abc digest", digest, 160'ha9993e364706816aba3e25717850c26c9cd0d89d);

        // R3: two-block message, second block continues
        msg56 = "abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq";
        run_block({msg56, 8'h80, 56'h0}, 1'b1, 1'b0);
        run_block({448'h0, 64'd448}, 1'b0, 1'b1);
        chk("R3 two-block digest", digest, 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1);

        // R9: digest holds while idle
        held = digest;
        repeat (7) @(negedge clk);
        chk("R9 digest idle hold", digest, held);

        // R8: random blocks and chaining flags
        for (int n = 0; n < 24; n++) begin
            for (int j = 0; j < 16; j++) b[511-32*j -: 32] = $urandom;
            run_block(b, (n == 0) ? 1'b1 : 1'($urandom % 3 == 0), (n % 3 == 1));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule